// File: doc/BRIEF.md
# Per-Timeslot Payload Conditioner

This block sits in the transmit path of a 32-slot, byte-wide frame stream. Each byte arrives with a strobe and its slot index. The block looks up the slot's control setting and rewrites the byte before it goes on. Depending on that setting, the byte can be passed through, have some of its bits inverted, be swapped for the slot's idle code, or be swapped for a G.711 digital milliwatt sample. It can also carry a byte from the payload loopback input, be replaced by the next byte of a test-pattern stream, or be copied out to a test-pattern checker.

A host write port fills two 32-entry tables: one holds the per-slot control fields and the other holds the per-slot idle codes. Writes land in a staging copy. That copy becomes active only after the last slot of the current frame, so no frame is processed with a mix of old and new settings. The conditioned byte appears one clock after its strobe.

Top module: `slot_conditioner`

## Requirements
- R1: After reset, outValid, outByte, exValid and patTake are 0. Both active tables hold all zeros, so every slot passes unchanged. The milliwatt phase of every slot is 0.
- R2: The control entry is 5 bits wide. Bits [2:0] are the action select, bit 3 is the test flag and bit 4 is the loopback flag; bits 7:5 of a written control byte are ignored. Select 000 passes the byte. Select 001 inverts bits 2, 4, 6 and 8 (mask 0xAA, with bit 1 as the LSB). Select 010 inverts bits 1, 3, 5 and 7 (mask 0x55). Select 011 inverts all bits. Each strobed byte gives outValid high with the result on outByte exactly one clock later.
- R3: Select 100 replaces the byte with the slot's idle code.
- R4: If the test flag is set and extractMode is 1, the slot's transmit byte is forwarded unchanged on outByte, and in the same cycle exValid is high with exByte equal to that byte. In every other case exValid is low.
- R5: If the loopback flag is set and the slot is not being extracted, outByte carries loopByte. Loopback overrides every lower-priority action.
- R6: If the test flag is set, extractMode is 0, and neither loopback nor milliwatt applies, outByte carries patByte. In that case patTake is high in the strobe cycle, and it is low at all other times. Successive consumed bytes form one continuous stream across slots and frames.
- R7: Select 101 emits the A-law sequence 34,21,21,34,B4,A1,A1,B4 (hex). Selects 110 and 111 emit the µ-law sequence 1E,0B,0B,1E,9E,8B,8B,9E (hex). Milliwatt ranks above test-pattern, idle and inversion, and below extraction and loopback.
- R8: Each slot has its own 3-bit milliwatt phase. The phase advances by one, wrapping after 8, only when that slot emits a milliwatt byte.
- R9: A host write with hostWrSel=0 stages a control entry and one with hostWrSel=1 stages an idle code. Staged values take effect starting with the first slot after the next strobe of slot 31, and not within the frame in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host table write strobe |
| hostWrSel | input | 1 | 0 = control table, 1 = idle-code table |
| hostWrAddr | input | 5 | Slot addressed by the write |
| hostWrData | input | 8 | Write data |
| byteStb | input | 1 | A slot byte is present this cycle |
| slotIdx | input | 5 | Slot number of the present byte |
| txByte | input | 8 | Transmit byte for the slot |
| loopByte | input | 8 | Payload loopback byte |
| patByte | input | 8 | Current test-pattern byte |
| extractMode | input | 1 | 1 = test slots are extracted, 0 = test slots are replaced |
| patTake | output | 1 | patByte is consumed this cycle |
| outValid | output | 1 | outByte holds a new conditioned byte |
| outByte | output | 8 | Conditioned byte |
| exValid | output | 1 | exByte holds an extracted byte |
| exByte | output | 8 | Extracted byte for the checker |

## Verification
Several properties are checked on every cycle:
- at most one override action is chosen for a strobe;
- patTake only occurs on a strobe in replace mode;
- an extracted byte always matches the forwarded byte;
- the active tables stay frozen except at a frame end;
- a milliwatt use steps only its own slot's phase.

Other behaviour can only be shown by the bench scenarios. These cover the actual byte values for all 32 combinations of select, test and loopback flags under both modes, and the exact milliwatt sequences and their wrap. They also cover the continuity of the test-pattern stream across slots and frames, and the one-frame deferral of host writes issued mid-frame.

// File: rtl/slot_cond_pkg.sv
package slot_cond_pkg;
  localparam int BYTE_W = 8;
  localparam int CTL_W  = 5;
  localparam int PH_W   = 3;

  typedef enum logic [2:0] {
    SEL_PASS     = 3'b000,
    SEL_INV_EVEN = 3'b001,
    SEL_INV_ODD  = 3'b010,
    SEL_INV_ALL  = 3'b011,
    SEL_IDLE     = 3'b100,
    SEL_MW_A     = 3'b101,
    SEL_MW_U0    = 3'b110,
    SEL_MW_U1    = 3'b111
  } selCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              stb;
    logic              takeEx;
    logic              takeLoop;
    logic              takeMw;
    logic              takePat;
    logic              takeIdle;
    logic [BYTE_W-1:0] xorMask;
    logic [BYTE_W-1:0] mwByte;
    logic [BYTE_W-1:0] idleByte;
  } condCmd_t;

  // milliwatt sample: symmetric half-cycle, second half has sign bit set
  function automatic logic [BYTE_W-1:0] mwLookup(input logic muLaw, input logic [PH_W-1:0] ph);
    logic outer;
    logic [BYTE_W-1:0] b;
    outer = (ph[1:0] == 2'd0) || (ph[1:0] == 2'd3);
    if (muLaw) b = outer ? 8'h1E : 8'h0B;
    else       b = outer ? 8'h34 : 8'h21;
    b[7] = ph[2];
    return b;
  endfunction
endpackage

// File: rtl/slot_cond_ctrl.sv
module slot_cond_ctrl
  import slot_cond_pkg::*;
#(
  parameter int NSLOT = 32,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostWrSel,
  input  logic [SW-1:0]     hostWrAddr,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic              byteStb,
  input  logic [SW-1:0]     slotIdx,
  input  logic              extractMode,
  output logic              patTake,
  output condCmd_t          cmd
);
  logic [NSLOT-1:0][CTL_W-1:0]  shCtl, liveCtl;
  logic [NSLOT-1:0][BYTE_W-1:0] shIdle, liveIdle;
  logic [NSLOT-1:0][PH_W-1:0]   phase;
  logic [CTL_W-1:0] curCtl;
  selCode_t sel;
  logic testBit, loopBit, isMw, frameEnd;

  assign frameEnd = byteStb && (slotIdx == SW'(NSLOT - 1));

  // staging tables and frame-boundary commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shCtl    <= '0;
      shIdle   <= '0;
      liveCtl  <= '0;
      liveIdle <= '0;
    end else begin
      if (hostWrEn) begin
        if (hostWrSel) shIdle[hostWrAddr] <= hostWrData;
        else           shCtl[hostWrAddr]  <= hostWrData[CTL_W-1:0];
      end
      if (frameEnd) begin
        liveCtl  <= shCtl;
        liveIdle <= shIdle;
      end
    end
  end

  assign curCtl  = liveCtl[slotIdx];
  assign sel     = selCode_t'(curCtl[2:0]);
  assign testBit = curCtl[3];
  assign loopBit = curCtl[4];
  assign isMw    = curCtl[2] && (curCtl[1] || curCtl[0]);

  // fixed-priority action resolution
  always_comb begin
    cmd = '0;
    cmd.stb = byteStb;
    if (byteStb) begin
      if (testBit && extractMode) cmd.takeEx   = 1'b1;
      else if (loopBit)           cmd.takeLoop = 1'b1;
      else if (isMw)              cmd.takeMw   = 1'b1;
      else if (testBit)           cmd.takePat  = 1'b1;
      else if (sel == SEL_IDLE)   cmd.takeIdle = 1'b1;
    end
    case (sel)
      SEL_INV_EVEN: cmd.xorMask = 8'hAA;
      SEL_INV_ODD:  cmd.xorMask = 8'h55;
      SEL_INV_ALL:  cmd.xorMask = 8'hFF;
      default:      cmd.xorMask = 8'h00;
    endcase
    cmd.mwByte   = mwLookup(curCtl[1], phase[slotIdx]);
    cmd.idleByte = liveIdle[slotIdx];
  end

  assign patTake = cmd.takePat;

  // one milliwatt phase counter per slot
  for (genvar g = 0; g < NSLOT; g++) begin : g_phase
    logic [PH_W-1:0] ph;
    always_ff @(posedge clk) begin
      if (!rstN) ph <= '0;
      else if (cmd.takeMw && (slotIdx == SW'(g))) ph <= ph + 1'b1;
    end
    assign phase[g] = ph;
  end

  // R5, R7: never more than one override chosen
  p_one_action_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.takeEx, cmd.takeLoop, cmd.takeMw, cmd.takePat, cmd.takeIdle}));
  // R6: pattern consumed only on a strobe in replace mode
  p_pat_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    patTake |-> (byteStb && !extractMode));
  // R9: active tables change only at the frame end
  p_live_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> ($stable(liveCtl) && $stable(liveIdle)));
  // R8: milliwatt use steps that slot's phase by one
  p_mw_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.takeMw |=> (phase[$past(slotIdx)] == $past(phase[slotIdx]) + 3'd1));
endmodule

// File: rtl/slot_cond_dp.sv
module slot_cond_dp
  import slot_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  condCmd_t          cmd,
  input  logic [BYTE_W-1:0] txByte,
  input  logic [BYTE_W-1:0] loopByte,
  input  logic [BYTE_W-1:0] patByte,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              exValid,
  output logic [BYTE_W-1:0] exByte
);
  logic [BYTE_W-1:0] nextByte;

  always_comb begin
    if (cmd.takeEx)        nextByte = txByte;
    else if (cmd.takeLoop) nextByte = loopByte;
    else if (cmd.takeMw)   nextByte = cmd.mwByte;
    else if (cmd.takePat)  nextByte = patByte;
    else if (cmd.takeIdle) nextByte = cmd.idleByte;
    else                   nextByte = txByte ^ cmd.xorMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outByte  <= '0;
      exValid  <= 1'b0;
      exByte   <= '0;
    end else begin
      outValid <= cmd.stb;
      exValid  <= cmd.takeEx;
      if (cmd.stb)    outByte <= nextByte;
      if (cmd.takeEx) exByte  <= txByte;
    end
  end

  // R4: extracted byte is also the forwarded byte
  p_extract_fwd_r4: assert property (@(posedge clk) disable iff (!rstN)
    exValid |-> (outValid && (exByte == outByte)));
  // R2: output byte holds when no strobe
  p_hold_out_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.stb |=> $stable(outByte));
endmodule

// File: rtl/slot_conditioner.sv
module slot_conditioner
  import slot_cond_pkg::*;
#(
  parameter int NSLOT = 32,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostWrSel,
  input  logic [SW-1:0]     hostWrAddr,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic              byteStb,
  input  logic [SW-1:0]     slotIdx,
  input  logic [BYTE_W-1:0] txByte,
  input  logic [BYTE_W-1:0] loopByte,
  input  logic [BYTE_W-1:0] patByte,
  input  logic              extractMode,
  output logic              patTake,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              exValid,
  output logic [BYTE_W-1:0] exByte
);
  condCmd_t cmd;

  slot_cond_ctrl #(.NSLOT(NSLOT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostWrSel(hostWrSel),
    .hostWrAddr(hostWrAddr), .hostWrData(hostWrData),
    .byteStb(byteStb), .slotIdx(slotIdx), .extractMode(extractMode),
    .patTake(patTake), .cmd(cmd)
  );

  slot_cond_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .txByte(txByte), .loopByte(loopByte), .patByte(patByte),
    .outValid(outValid), .outByte(outByte),
    .exValid(exValid), .exByte(exByte)
  );
endmodule

// File: tb/slot_conditioner_bench.sv
module slot_conditioner_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostWrSel = 1'b0;
  logic [4:0] hostWrAddr = '0;
  logic [7:0] hostWrData = '0;
  logic byteStb = 1'b0;
  logic [4:0] slotIdx = '0;
  logic [7:0] txByte = '0, loopByte = '0, patByte = '0;
  logic extractMode = 1'b0;
  logic patTake, outValid, exValid;
  logic [7:0] outByte, exByte;

  int total = 0;
  int fails = 0;
  logic [4:0] mCtl[32], sCtl[32];
  logic [7:0] mIdle[32], sIdle[32];
  int mPh[32];
  int patCnt = 0;

  always #2 clk = ~clk;

  slot_conditioner u_slot_conditioner (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrSel(hostWrSel),
    .hostWrAddr(hostWrAddr), .hostWrData(hostWrData), .byteStb(byteStb),
    .slotIdx(slotIdx), .txByte(txByte), .loopByte(loopByte), .patByte(patByte),
    .extractMode(extractMode), .patTake(patTake), .outValid(outValid),
    .outByte(outByte), .exValid(exValid), .exByte(exByte)
  );

  function automatic logic [7:0] patVal(int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] mwRef(bit mu, int ph);
    logic [7:0] a, u;
    case (ph & 7)
      0: begin a = 8'h34; u = 8'h1E; end
      1: begin a = 8'h21; u = 8'h0B; end
      2: begin a = 8'h21; u = 8'h0B; end
      3: begin a = 8'h34; u = 8'h1E; end
      4: begin a = 8'hB4; u = 8'h9E; end
      5: begin a = 8'hA1; u = 8'h8B; end
      6: begin a = 8'hA1; u = 8'h8B; end
      default: begin a = 8'hB4; u = 8'h9E; end
    endcase
    return mu ? u : a;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(bit isIdle, int addr, logic [7:0] data);
    @(negedge clk);
    byteStb = 1'b0;
    hostWrEn = 1'b1; hostWrSel = isIdle;
    hostWrAddr = 5'(addr); hostWrData = data;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
    if (isIdle) sIdle[addr] = data;
    else sCtl[addr] = data[4:0];
  endtask

  task automatic sendSlot(int s, int frame, bit mode);
    logic [7:0] tx, lb, expOut;
    logic [4:0] c;
    bit expEx, expTake;
    string req;
    tx = 8'((s * 29 + frame * 71 + 11) & 255);
    lb = 8'((s * 13 + frame * 5 + 200) & 255);
    @(negedge clk);
    byteStb = 1'b1; slotIdx = 5'(s); txByte = tx; loopByte = lb;
    patByte = patVal(patCnt); extractMode = mode;
    c = mCtl[s];
    expEx = 1'b0; expTake = 1'b0;
    if (c[3] && mode) begin
      expOut = tx; expEx = 1'b1; req = "R4";
    end else if (c[4]) begin
      expOut = lb; req = "R5";
    end else if (c[2] && (c[1] || c[0])) begin
      expOut = mwRef(c[1], mPh[s]); mPh[s] = (mPh[s] + 1) & 7; req = "R7_R8";
    end else if (c[3]) begin
      expOut = patVal(patCnt); expTake = 1'b1; patCnt++; req = "R6";
    end else if (c[2:0] == 3'b100) begin
      expOut = mIdle[s]; req = "R3";
    end else begin
      case (c[1:0])
        2'b00: expOut = tx;
        2'b01: expOut = tx ^ 8'hAA;
        2'b10: expOut = tx ^ 8'h55;
        default: expOut = ~tx;
      endcase
      req = "R2";
    end
    #1;
    check(patTake == expTake, "R6", "patTake", patTake, expTake);
    @(posedge clk); #1;
    check(outValid == 1'b1, "R2", "outValid", outValid, 1);
    check(outByte == expOut, req, $sformatf("outByte slot %0d frame %0d", s, frame), outByte, expOut);
    check(exValid == expEx, "R4", "exValid", exValid, expEx);
    if (expEx) check(exByte == tx, "R4", "exByte", exByte, tx);
    if (s == 31) begin
      for (int i = 0; i < 32; i++) begin mCtl[i] = sCtl[i]; mIdle[i] = sIdle[i]; end
    end
  endtask

  task automatic runFrame(int frame, bit mode, int wrAfter);
    for (int s = 0; s < 32; s++) begin
      sendSlot(s, frame, mode);
      if (s == wrAfter) begin
        hostWrite(1'b0, 20, 8'hE5);   // R9 mid-frame write; upper bits ignored (R2)
        hostWrite(1'b0, 6, 8'h08);
        hostWrite(1'b1, 4, 8'h5A);    // R3 new idle code
      end
    end
    @(negedge clk);
    byteStb = 1'b0;
    @(posedge clk); #1;
    check(outValid == 1'b0, "R2", "outValid idle", outValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mCtl[i] = '0; sCtl[i] = '0; mIdle[i] = '0; sIdle[i] = '0; mPh[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R1", "outValid reset", outValid, 0);
    check(outByte == 8'h00, "R1", "outByte reset", outByte, 0);
    check(exValid == 1'b0, "R1", "exValid reset", exValid, 0);
    check(patTake == 1'b0, "R1", "patTake reset", patTake, 0);
    @(negedge clk); rstN = 1'b1;
    // stage every select/test/loop combination: slot s gets control s (R9)
    for (int s = 0; s < 32; s++) begin
      hostWrite(1'b0, s, 8'(s));
      hostWrite(1'b1, s, 8'((s * 9 + 3) & 255));
    end
    runFrame(0, 1'b0, -1);   // R1/R9: still pass-through, staged not active
    for (int f = 1; f < 12; f++) begin
      runFrame(f, (f == 3 || f == 4 || f == 9), (f == 6) ? 10 : -1);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule